// File: doc/BRIEF.md
# Erased-Sector Bit-Flip Detector

When the ECC decoder reports more errors in a sector than it can correct, the sector may still be a freshly erased one. Erased flash reads as all ones, including the check bytes. Those check bytes do not match the code computed over all-ones data, so the decoder gives up. This block receives the sector's bytes one per cycle and counts the zero bits in the data group and in the ECC group separately. It then decides whether the sector is an erased sector with a few flipped bits or a true uncorrectable error.

The data group always comes first and ends with a last-byte marker. The ECC group follows and also ends with a marker. The decoder's error count is sampled on the cycle of the ECC group's final byte. One cycle later the block pulses a result. The result says whether the verdict is erased or uncorrectable, and for an erased sector it gives the data flip count. A separate force-to-ones signal tells the buffer memory to overwrite the sector's data with 0xFF. Each group counter saturates one above the correction limit, so each counter needs only a few bits.

Top module: `erased_sector_check`

## Requirements
- R1: During reset and in the first cycle after it, all outputs are 0.
- R2: The data group is the bytes up to and including the first byte with in_last=1. The ECC group is the bytes from there up to the next byte with in_last=1. Zero bits in the two groups are counted separately: zeros in ECC bytes never add to res_flips.
- R3: Each group count saturates at FLIP_LIMIT+1 (9). A sector whose 512 data bytes are all 0x00 (4096 zero bits) is uncorrectable.
- R4: If dec_errs sampled with the final byte is FLIP_LIMIT (8) or less, the check is skipped. res_valid pulses with res_erased=0, res_uncorr=0, res_flips=0 and force_ff=0.
- R5: If dec_errs > 8 and data zeros + ECC zeros <= 8, res_erased=1 and res_flips equals the data zero count. This includes a sum of exactly 8.
- R6: force_ff=1 exactly when res_erased=1 and the data zero count is nonzero. An erased sector whose zeros all lie in the ECC group gives force_ff=0.
- R7: If dec_errs > 8 and the sum of zeros exceeds 8, res_uncorr=1 and res_erased=0.
- R8: res_valid is a one-cycle pulse in the cycle after the ECC group's final byte. When res_valid is 0, res_erased, res_uncorr, res_flips and force_ff are 0.
- R9: Cycles with in_valid=0 have no effect, whatever in_byte and in_last carry.
- R10: dec_errs is used only on the cycle of the ECC group's final byte. Its value on other cycles does not change the result.
- R11: A new sector may start on the cycle right after a final byte. Both counts start again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is presented this cycle |
| in_byte | input | 8 | Sector byte (data group first, then ECC group) |
| in_last | input | 1 | Marks the final byte of the current group |
| dec_errs | input | ERR_W (4) | Error count from the decoder, sampled with the ECC group's final byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_erased | output | 1 | Sector treated as erased |
| res_uncorr | output | 1 | Sector is uncorrectable |
| res_flips | output | clog2(FLIP_LIMIT+2) (4) | Zero bits found in the data group (corrected bit count) |
| force_ff | output | 1 | Buffer must overwrite the sector data with 0xFF |

## Verification
A wrong group phase shows at the next result: ECC zeros appear in res_flips, or a verdict arrives one group early or late. A count that is not cleared or not saturated turns an erased verdict into an uncorrectable one, or the reverse, at the end of that same sector or the next one. The bench model counts unbounded integers and is compared on every cycle. A broken strobe timing or a result field left set is therefore caught in the first cycle it differs.

// File: rtl/erz_pkg.sv
package erz_pkg;
  localparam int ERZ_BYTE_W = 8;

  typedef enum logic {GRP_DATA = 1'b0, GRP_ECC = 1'b1} grp_e;

  // number of cleared bits in one byte
  function automatic int zero_bits(input logic [ERZ_BYTE_W-1:0] b);
    int n;
    n = 0;
    for (int i = 0; i < ERZ_BYTE_W; i++) begin
      if (!b[i]) n++;
    end
    return n;
  endfunction

  // addition clipped at cap
  function automatic int sat_add(input int a, input int b, input int cap);
    return (a + b > cap) ? cap : a + b;
  endfunction

  // combined threshold decision
  function automatic logic within_limit(input int d, input int e, input int lim);
    return (d + e) <= lim;
  endfunction
endpackage

// File: rtl/erz_phase.sv
module erz_phase
  import erz_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  output logic grp_data_en,
  output logic grp_ecc_en,
  output logic sector_end
);
  grp_e grp_q;

  assign grp_data_en = in_valid && (grp_q == GRP_DATA);
  assign grp_ecc_en  = in_valid && (grp_q == GRP_ECC);
  assign sector_end  = grp_ecc_en && in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= GRP_DATA;
    end else if (in_valid && in_last) begin
      grp_q <= (grp_q == GRP_DATA) ? GRP_ECC : GRP_DATA;
    end
  end
endmodule

// File: rtl/erz_zero_tally.sv
module erz_zero_tally
  import erz_pkg::*;
#(
  parameter int LIMIT = 8,
  parameter int CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  clr,
  input  logic [ERZ_BYTE_W-1:0] byte_in,
  output logic [CNT_W-1:0]      cnt_q,
  output logic [CNT_W-1:0]      cnt_nx
);
  localparam int CAP = LIMIT + 1;

  always_comb begin
    cnt_nx = cnt_q;
    if (en) cnt_nx = CNT_W'(sat_add(int'(cnt_q), zero_bits(byte_in), CAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/erz_verdict.sv
module erz_verdict
  import erz_pkg::*;
#(
  parameter int LIMIT = 8,
  parameter int CNT_W = 4,
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [CNT_W-1:0] data_cnt,
  input  logic [CNT_W-1:0] ecc_cnt,
  input  logic [ERR_W-1:0] dec_errs,
  output logic             res_valid,
  output logic             res_erased,
  output logic             res_uncorr,
  output logic [CNT_W-1:0] res_flips,
  output logic             force_ff
);
  logic engage, fits;

  assign engage = int'(dec_errs) > LIMIT;
  assign fits   = within_limit(int'(data_cnt), int'(ecc_cnt), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_erased <= 1'b0;
      res_uncorr <= 1'b0;
      res_flips  <= '0;
      force_ff   <= 1'b0;
    end else begin
      res_valid  <= done;
      res_erased <= done && engage && fits;
      res_uncorr <= done && engage && !fits;
      res_flips  <= (done && engage && fits) ? data_cnt : '0;
      force_ff   <= done && engage && fits && (data_cnt != '0);
    end
  end
endmodule

// File: rtl/erased_sector_check.sv
module erased_sector_check
  import erz_pkg::*;
#(
  parameter int FLIP_LIMIT = 8,
  parameter int ERR_W      = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic [7:0]                         in_byte,
  input  logic                               in_last,
  input  logic [ERR_W-1:0]                   dec_errs,
  output logic                               res_valid,
  output logic                               res_erased,
  output logic                               res_uncorr,
  output logic [$clog2(FLIP_LIMIT+2)-1:0]    res_flips,
  output logic                               force_ff
);
  localparam int CNT_W = $clog2(FLIP_LIMIT + 2);
  localparam int N_GRP = 2;

  logic             grp_data_en, grp_ecc_en, sector_end;
  logic [N_GRP-1:0] grp_en;
  logic [CNT_W-1:0] cnt_q  [N_GRP];
  logic [CNT_W-1:0] cnt_nx [N_GRP];
  logic [CNT_W-1:0] data_cnt, ecc_cnt;

  erz_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .grp_data_en (grp_data_en),
    .grp_ecc_en  (grp_ecc_en),
    .sector_end  (sector_end)
  );

  assign grp_en = {grp_ecc_en, grp_data_en};

  for (genvar g = 0; g < N_GRP; g++) begin : g_tally
    erz_zero_tally #(.LIMIT(FLIP_LIMIT), .CNT_W(CNT_W)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (grp_en[g]),
      .clr     (sector_end),
      .byte_in (in_byte),
      .cnt_q   (cnt_q[g]),
      .cnt_nx  (cnt_nx[g])
    );
  end

  // data group is complete before the ECC group; ECC includes the final byte
  assign data_cnt = cnt_q[0];
  assign ecc_cnt  = cnt_nx[1];

  erz_verdict #(.LIMIT(FLIP_LIMIT), .CNT_W(CNT_W), .ERR_W(ERR_W)) u_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (sector_end),
    .data_cnt   (data_cnt),
    .ecc_cnt    (ecc_cnt),
    .dec_errs   (dec_errs),
    .res_valid  (res_valid),
    .res_erased (res_erased),
    .res_uncorr (res_uncorr),
    .res_flips  (res_flips),
    .force_ff   (force_ff)
  );
endmodule

// File: rtl/erz_checker.sv
module erz_checker #(
  parameter int FLIP_LIMIT = 8,
  parameter int ERR_W      = 4,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sector_end,
  input logic [ERR_W-1:0] dec_errs,
  input logic [CNT_W-1:0] data_q,
  input logic [CNT_W-1:0] ecc_q,
  input logic             res_valid,
  input logic             res_erased,
  input logic             res_uncorr,
  input logic [CNT_W-1:0] res_flips,
  input logic             force_ff
);
  AST_CNT_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(data_q) <= FLIP_LIMIT + 1) && (int'(ecc_q) <= FLIP_LIMIT + 1)); // R3
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sector_end |=> (data_q == '0) && (ecc_q == '0)); // R11
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    sector_end |=> res_valid); // R8
  AST_RESULT_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(sector_end)); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_erased && !res_uncorr && !force_ff && (res_flips == '0)); // R8
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_erased && res_uncorr)); // R7
  AST_FORCE_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    force_ff |-> res_erased && (res_flips != '0)); // R6
  AST_FLIPS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_erased |-> int'(res_flips) <= FLIP_LIMIT); // R5
  AST_SKIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_end && int'(dec_errs) <= FLIP_LIMIT) |=> !res_erased && !res_uncorr); // R4
endmodule

bind erased_sector_check erz_checker #(
  .FLIP_LIMIT (FLIP_LIMIT),
  .ERR_W      (ERR_W),
  .CNT_W      ($clog2(FLIP_LIMIT + 2))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sector_end (sector_end),
  .dec_errs   (dec_errs),
  .data_q     (cnt_q[0]),
  .ecc_q      (cnt_q[1]),
  .res_valid  (res_valid),
  .res_erased (res_erased),
  .res_uncorr (res_uncorr),
  .res_flips  (res_flips),
  .force_ff   (force_ff)
);

// File: tb/sim_erased_sector_check.sv
module sim_erased_sector_check;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 8;
  localparam int DATA_N     = 512;
  localparam int ECC_N      = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_last = 1'b0;
  logic [3:0] dec_errs = 4'h0;
  logic       res_valid, res_erased, res_uncorr, force_ff;
  logic [3:0] res_flips;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    run_cmp = 1'b0;
  string cur_tag = "R1";

  // reference state
  int mdz = 0, mez = 0;
  bit mph = 1'b0;
  bit e_valid = 0, e_erased = 0, e_uncorr = 0, e_force = 0;
  int e_flips = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erased_sector_check u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .dec_errs(dec_errs), .res_valid(res_valid),
    .res_erased(res_erased), .res_uncorr(res_uncorr),
    .res_flips(res_flips), .force_ff(force_ff)
  );

  function automatic int count_clear(input logic [7:0] b);
    int z = 0;
    logic [7:0] t = b;
    while (t != 8'hFF) begin
      t = t | (t + 8'h01);
      z++;
    end
    return z;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mdz <= 0; mez <= 0; mph <= 0;
      e_valid <= 0; e_erased <= 0; e_uncorr <= 0; e_force <= 0; e_flips <= 0;
    end else begin
      e_valid <= 0; e_erased <= 0; e_uncorr <= 0; e_force <= 0; e_flips <= 0;
      if (in_valid) begin
        if (!mph) begin
          mdz <= mdz + count_clear(in_byte);
          if (in_last) mph <= 1;
        end else if (in_last) begin
          e_valid <= 1;
          if (dec_errs > LIMIT) begin
            if (mdz + mez + count_clear(in_byte) <= LIMIT) begin
              e_erased <= 1; e_flips <= mdz; e_force <= (mdz != 0);
            end else begin
              e_uncorr <= 1;
            end
          end
          mdz <= 0; mez <= 0; mph <= 0;
        end else begin
          mez <= mez + count_clear(in_byte);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) begin
      check(res_valid == e_valid, "R8", "res_valid", res_valid, e_valid);
      check(res_erased == e_erased, cur_tag, "res_erased", res_erased, e_erased);
      check(res_uncorr == e_uncorr, cur_tag, "res_uncorr", res_uncorr, e_uncorr);
      check(int'(res_flips) == e_flips, cur_tag, "res_flips", res_flips, e_flips);
      check(force_ff == e_force, cur_tag, "force_ff", force_ff, e_force);
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog R8 actual=hang expected=done");
      finish_run();
    end
  end

  task automatic put(input logic [7:0] b, input bit last, input logic [3:0] e, input bit gap);
    in_valid = 1; in_byte = b; in_last = last; dec_errs = e;
    @(negedge clk);
    if (gap) begin
      // R9: idle cycle carrying junk must be ignored
      in_valid = 0; in_byte = 8'h00; in_last = 1; dec_errs = 4'hF;
      @(negedge clk);
    end
  endtask

  // dz < 0 means every data byte is 0x00
  task automatic sector(input string tag, input int dz, input int ez, input int errs, input bit gap);
    logic [3:0] noise;
    logic [7:0] b;
    cur_tag = tag;
    noise = (errs > LIMIT) ? 4'h0 : 4'hF; // R10: differs from the sampled value
    for (int i = 0; i < DATA_N; i++) begin
      if (dz < 0) b = 8'h00;
      else b = (i < dz) ? ~(8'h01 << (i % 8)) : 8'hFF;
      put(b, i == DATA_N - 1, noise, gap);
    end
    for (int i = 0; i < ECC_N; i++) begin
      b = (i < ez) ? ~(8'h80 >> (i % 8)) : 8'hFF;
      put(b, i == ECC_N - 1, (i == ECC_N - 1) ? 4'(errs) : noise, gap);
    end
    in_valid = 0; in_last = 0; in_byte = 8'hFF; dec_errs = noise;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(!res_valid && !res_erased && !res_uncorr && !force_ff && res_flips == 0,
          "R1", "outputs in reset", {res_valid, res_erased, res_uncorr, force_ff}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!res_valid && !res_erased && !res_uncorr && !force_ff && res_flips == 0,
          "R1", "outputs after reset", {res_valid, res_erased, res_uncorr, force_ff}, 0);
    run_cmp = 1;
    sector("R5", 0, 0, 12, 0);       // clean erased, no force (R6)
    @(negedge clk);
    sector("R6", 3, 2, 9, 0);        // erased, flips 3, force
    @(negedge clk);
    sector("R5", 8, 0, 15, 0);       // boundary sum 8
    sector("R11", 1, 0, 10, 0);      // back to back, counts restart
    @(negedge clk);
    sector("R7", 5, 4, 9, 0);        // sum 9 uncorrectable
    @(negedge clk);
    sector("R2", 0, 9, 11, 0);       // zeros only in ECC group: uncorrectable
    @(negedge clk);
    sector("R2", 0, 8, 11, 0);       // ECC zeros never reach res_flips (R6 no force)
    @(negedge clk);
    sector("R3", -1, 0, 14, 0);      // 4096 zero bits saturate
    @(negedge clk);
    sector("R4", 2, 1, 8, 0);        // decoder count at limit: skipped
    @(negedge clk);
    sector("R4", 20, 5, 3, 0);       // skipped even when dirty
    @(negedge clk);
    sector("R9", 2, 0, 15, 1);       // gaps with junk
    @(negedge clk);
    sector("R10", 4, 3, 9, 0);       // noise on dec_errs before final byte
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule